// File: doc/BRIEF.md
# Embedded-Clock 24-Bit Serial Framer

The block turns a 24-bit parallel word, presented once per parallel clock period, into a single serial bit stream. It runs at an idealized bit-rate clock that is 28 times the parallel clock. Every 28-bit frame opens with a high boundary bit and closes with a low one, so a receiver can recover the word clock from the stream itself. The two 12-bit halves of the word each carry a balance flag. A half is sent inverted whenever that keeps the running disparity of the line from drifting, which lets the link work through series capacitors.

The parallel clock is sampled in the bit-clock domain. An edge-select input chooses whether the rising or the falling parallel-clock edge captures the word. Frames repeat back to back from a free-running bit counter. If no new word arrives, the held word keeps being framed, so boundary bits never stop.

A data-enable input releases the serial line without stopping the framer. An active-low power-down freezes everything, clears the held word and the disparity, and gates the bit clock output. Leaving power-down, or leaving reset, starts with two training frames that give a receiver a clean edge to lock on.

Top module: `emb_clk_ser_framer`

## Requirements
- R1: While rst_ni is low, ser_oe_o, ser_o and bclk_o are all 0.
- R2: A frame is 28 bits long and is sent most significant first. The bits are, in order: a 1; data bits 23 down to 12 (possibly inverted); flag A; data bits 11 down to 0 (possibly inverted); flag B; a 0. Frames follow each other every 28 bit clocks. The first frame's leading bit appears after the second rising clk_i edge at which the block has seen pwdn_ni high out of reset or standby.
- R3: The first 2 frames after reset or standby are training frames: 14 ones followed by 14 zeros. They leave the running disparity unchanged.
- R4: Each half is coded against the running disparity RD, which is ones minus zeros over all frames sent since reset or standby. Let c = 2*ones(half) - 13 be the effect of sending the half unchanged with flag 0. The half is inverted and its flag set to 1 when RD>0 and c>0, or when RD<0 and c<0. Otherwise it is sent unchanged with flag 0.
- R5: Measured at frame boundaries, the magnitude of the running disparity never exceeds 13.
- R6: With edge_sel_i high, data_i is captured on rising pclk_i edges; with it low, on falling edges. The captured word updates 3 clk_i edges after the pclk_i change is first sampled. Each data frame carries the word held when that frame is loaded.
- R7: When no capture edge occurs, every data frame re-sends the last held word, coded against the current disparity.
- R8: With den_i low, ser_oe_o and ser_o are 0 from the next clk_i edge. Framing, capture and disparity tracking continue, so frames sent after den_i returns high match an uninterrupted sequence. bclk_o keeps running.
- R9: Two clk_i edges after pwdn_ni goes low, ser_oe_o and ser_o are 0 and bclk_o is held low. The held word and the disparity are cleared, so after wake-up the training frames repeat and data frames start from word 0 and disparity 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock, 28 times the parallel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pclk_i | input | 1 | Parallel word clock, sampled in the clk_i domain |
| data_i | input | 24 | Parallel data word |
| edge_sel_i | input | 1 | 1: capture on rising pclk_i edge, 0: on falling edge |
| den_i | input | 1 | Serial output drive enable |
| pwdn_ni | input | 1 | Active-low standby |
| ser_o | output | 1 | Serial bit, 0 when not driven |
| ser_oe_o | output | 1 | Serial drive enable |
| bclk_o | output | 1 | Bit clock, gated low in standby |

## Verification
The hardest state to reach is a large running disparity. Random words keep it near zero, so the inversion rule and its bound are only exercised at the edges by long runs of unbalanced words. The stimulus therefore sends directed runs of all-ones and all-zeros words, half-balanced words and one-sided halves. Every observed frame is compared against a bench coder, and the disparity is also summed directly from the received bits. A second hard case is a word captured close to a frame boundary. The parallel clock is phased so that captures on either edge land well inside a frame. This makes the one-frame difference in latency between rising and falling capture visible after a standby with the edge select flipped.

// File: rtl/esf_pkg.sv
package esf_pkg;
  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_SYNC = 2'd1,
    LD_DATA = 2'd2
  } load_e;
endpackage

// File: rtl/esf_edge_capture.sv
module esf_edge_capture #(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              pclk_i,
  input  logic              edge_sel_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] word_o
);
  localparam int STAGES = 3;

  logic [STAGES-1:0] pipe_q;
  logic [DATA_W-1:0] word_q;
  logic rise_w, fall_w, take_w;

  // two synchronizer stages plus one history stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], pclk_i};
  end

  assign rise_w = pipe_q[1] & ~pipe_q[2];
  assign fall_w = ~pipe_q[1] & pipe_q[2];
  assign take_w = edge_sel_i ? rise_w : fall_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (!run_i) word_q <= '0;
    else if (take_w) word_q <= data_i;
  end

  assign word_o = word_q;
endmodule

// File: rtl/esf_half_coder.sv
module esf_half_coder #(
  parameter int HALF_W = 12,
  parameter int RD_W   = 6
) (
  input  logic [HALF_W-1:0]      half_i,
  input  logic signed [RD_W-1:0] rd_i,
  output logic [HALF_W-1:0]      bits_o,
  output logic                   inv_o,
  output logic signed [RD_W-1:0] rd_o
);
  int ones;
  int rd_now;
  int keep_c;

  always_comb begin
    ones = 0;
    for (int i = 0; i < HALF_W; i++) ones += int'(half_i[i]);
  end

  // keep_c: disparity added by the half sent as is with flag 0
  always_comb begin
    rd_now = int'(rd_i);
    keep_c = 2 * ones - HALF_W - 1;
    inv_o  = (rd_now > 0 && keep_c > 0) || (rd_now < 0 && keep_c < 0);
    bits_o = inv_o ? ~half_i : half_i;
    rd_o   = RD_W'(rd_now + (inv_o ? -keep_c : keep_c));
  end
endmodule

// File: rtl/esf_shifter.sv
module esf_shifter
  import esf_pkg::*;
#(
  parameter int FRAME_W     = 28,
  parameter int SYNC_FRAMES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [FRAME_W-1:0] data_frame_i,
  output load_e              kind_o,
  output logic               last_o,
  output logic               bit_o
);
  localparam int CNT_W  = $clog2(FRAME_W);
  localparam int SYNC_W = $clog2(SYNC_FRAMES + 1);
  localparam logic [FRAME_W-1:0] SYNC_PAT =
    {{(FRAME_W/2){1'b1}}, {(FRAME_W - FRAME_W/2){1'b0}}};

  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] sh_q;
  logic [SYNC_W-1:0]  sync_left_q;
  logic               first_q;
  logic               load_w;

  assign last_o = (cnt_q == CNT_W'(FRAME_W - 1));
  assign load_w = run_i && (first_q || last_o);

  always_comb begin
    if (!load_w)                 kind_o = LD_IDLE;
    else if (sync_left_q != '0)  kind_o = LD_SYNC;
    else                         kind_o = LD_DATA;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      sh_q        <= '0;
      sync_left_q <= SYNC_W'(SYNC_FRAMES);
      first_q     <= 1'b1;
    end else if (!run_i) begin
      cnt_q       <= '0;
      sh_q        <= '0;
      sync_left_q <= SYNC_W'(SYNC_FRAMES);
      first_q     <= 1'b1;
    end else if (load_w) begin
      cnt_q   <= '0;
      first_q <= 1'b0;
      if (kind_o == LD_SYNC) begin
        sh_q        <= SYNC_PAT;
        sync_left_q <= sync_left_q - SYNC_W'(1);
      end else begin
        sh_q <= data_frame_i;
      end
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
      sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
    end
  end

  assign bit_o = sh_q[FRAME_W-1];
endmodule

// File: rtl/emb_clk_ser_framer.sv
module emb_clk_ser_framer
  import esf_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int SYNC_FRAMES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pclk_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              edge_sel_i,
  input  logic              den_i,
  input  logic              pwdn_ni,
  output logic              ser_o,
  output logic              ser_oe_o,
  output logic              bclk_o
);
  localparam int HALF_W  = DATA_W / 2;
  localparam int FRAME_W = DATA_W + 4;
  localparam int RD_W    = $clog2(2 * HALF_W + 3) + 1;

  logic                   run_q, oe_q;
  logic [DATA_W-1:0]      word_w;
  logic signed [RD_W-1:0] rd_q;
  logic signed [RD_W-1:0] rd_chain [3];
  logic [HALF_W-1:0]      coded_w [2];
  logic [1:0]             inv_w;
  logic [FRAME_W-1:0]     frame_w;
  load_e                  kind_w;
  logic                   last_w, frame_bit, is_load, is_sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      run_q <= pwdn_ni;
      oe_q  <= run_q & den_i;
    end
  end

  esf_edge_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_q),
    .pclk_i     (pclk_i),
    .edge_sel_i (edge_sel_i),
    .data_i     (data_i),
    .word_o     (word_w)
  );

  assign rd_chain[0] = rd_q;

  for (genvar h = 0; h < 2; h++) begin : g_half
    esf_half_coder #(.HALF_W(HALF_W), .RD_W(RD_W)) u_coder (
      .half_i (word_w[DATA_W-1-h*HALF_W -: HALF_W]),
      .rd_i   (rd_chain[h]),
      .bits_o (coded_w[h]),
      .inv_o  (inv_w[h]),
      .rd_o   (rd_chain[h+1])
    );
  end

  assign frame_w = {1'b1, coded_w[0], inv_w[0], coded_w[1], inv_w[1], 1'b0};

  esf_shifter #(.FRAME_W(FRAME_W), .SYNC_FRAMES(SYNC_FRAMES)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run_q),
    .data_frame_i (frame_w),
    .kind_o       (kind_w),
    .last_o       (last_w),
    .bit_o        (frame_bit)
  );

  assign is_load = (kind_w != LD_IDLE);
  assign is_sync = (kind_w == LD_SYNC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rd_q <= '0;
    else if (!run_q)            rd_q <= '0;
    else if (kind_w == LD_DATA) rd_q <= rd_chain[2];
  end

  assign ser_o    = frame_bit & oe_q;
  assign ser_oe_o = oe_q;
  assign bclk_o   = clk_i & run_q;
endmodule

// File: rtl/esf_checker.sv
module esf_checker #(
  parameter int HALF_W = 12,
  parameter int RD_W   = 6
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   den_i,
  input logic                   pwdn_ni,
  input logic                   ser_oe_o,
  input logic                   is_load,
  input logic                   is_sync,
  input logic                   last_w,
  input logic                   frame_bit,
  input logic signed [RD_W-1:0] rd_q
);
  localparam int BOUND = HALF_W + 1;

  AST_FRAME_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_load |=> frame_bit) else $error("frame start bit"); // R2

  AST_STOP_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_w |-> !frame_bit) else $error("frame stop bit"); // R2

  AST_SYNC_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_sync |=> $stable(rd_q)) else $error("training frame moved disparity"); // R3

  AST_RD_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(rd_q) <= BOUND) && (int'(rd_q) >= -BOUND)) else $error("disparity bound"); // R5

  AST_DEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !den_i |=> !ser_oe_o) else $error("drive with den low"); // R8

  AST_STANDBY_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(pwdn_ni, 2) |-> !ser_oe_o) else $error("drive in standby"); // R9

  AST_STANDBY_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(pwdn_ni, 2) |-> (rd_q == '0)) else $error("disparity kept in standby"); // R9
endmodule

bind emb_clk_ser_framer esf_checker #(.HALF_W(HALF_W), .RD_W(RD_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .den_i     (den_i),
  .pwdn_ni   (pwdn_ni),
  .ser_oe_o  (ser_oe_o),
  .is_load   (is_load),
  .is_sync   (is_sync),
  .last_w    (last_w),
  .frame_bit (frame_bit),
  .rd_q      (rd_q)
);

// File: tb/sim_emb_clk_ser_framer.sv
module sim_emb_clk_ser_framer;
  localparam int CLK_P = 10;
  localparam logic [27:0] SYNC_PAT = {{14{1'b1}}, {14{1'b0}}};

  logic clk = 1'b0;
  logic rst_n, pclk, edge_sel, den, pwdn;
  logic [23:0] data;
  logic ser, oe, bclk;

  int checks = 0, fails = 0;
  int rd_m, sync_left_m, rd_obs, max_obs;
  bit obs_valid, done = 1'b0;
  logic [23:0] hold_m, cur_data;

  always #(CLK_P/2) clk = ~clk;

  emb_clk_ser_framer u0 (
    .clk_i(clk), .rst_ni(rst_n), .pclk_i(pclk), .data_i(data),
    .edge_sel_i(edge_sel), .den_i(den), .pwdn_ni(pwdn),
    .ser_o(ser), .ser_oe_o(oe), .bclk_o(bclk)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // coder written from the balance rule
  function automatic logic [27:0] enc(input logic [23:0] w, inout int rd);
    logic [11:0] a, b;
    logic fa, fb;
    int d;
    a = w[23:12];
    b = w[11:0];
    d = 2 * $countones(a) - 13;
    fa = (rd > 0 && d > 0) || (rd < 0 && d < 0);
    if (fa) begin a = ~a; d = -d; end
    rd += d;
    d = 2 * $countones(b) - 13;
    fb = (rd > 0 && d > 0) || (rd < 0 && d < 0);
    if (fb) begin b = ~b; d = -d; end
    rd += d;
    return {1'b1, a, fa, b, fb, 1'b0};
  endfunction

  task automatic model_clear();
    rd_m = 0; hold_m = '0; sync_left_m = 2; rd_obs = 0; obs_valid = 1'b1;
  endtask

  task automatic chk_bclk(input logic exp, input string req);
    @(posedge clk);
    #(CLK_P/4);
    chk(bclk === exp, req, "bclk_o", 64'(bclk), 64'(exp));
    @(negedge clk);
  endtask

  // entered at the negedge after a frame load
  task automatic run_frames(input int n, input bit pclk_on, input bit fixed_on,
                            input logic [23:0] fixed, input logic den_v,
                            input string req);
    for (int f = 0; f < n; f++) begin
      logic [27:0] expf, got, shown;
      logic exp_oe;
      bit oe_ok, was_sync;
      exp_oe = den;
      was_sync = (sync_left_m > 0);
      if (was_sync) begin
        expf = SYNC_PAT;
        sync_left_m--;
      end else begin
        expf = enc(hold_m, rd_m);
      end
      got = '0;
      oe_ok = 1'b1;
      for (int j = 0; j < 28; j++) begin
        got[27-j] = ser;
        if (oe !== exp_oe) oe_ok = 1'b0;
        if (pclk_on && j == 9) begin
          pclk = 1'b1;
          if (edge_sel) hold_m = cur_data;
        end
        if (pclk_on && j == 23) begin
          pclk = 1'b0;
          if (!edge_sel) hold_m = cur_data;
        end
        if (j == 16) begin
          cur_data = fixed_on ? fixed : 24'($urandom);
          data = cur_data;
        end
        if (j == 27) den = den_v;
        @(negedge clk);
      end
      shown = exp_oe ? expf : '0;
      chk(got === shown && oe_ok, was_sync ? "R3" : req, "frame",
          64'(got), 64'(shown));
      if (exp_oe && obs_valid) begin
        rd_obs += 2 * $countones(got) - 28;
        if (rd_obs > max_obs) max_obs = rd_obs;
        if (-rd_obs > max_obs) max_obs = -rd_obs;
      end else begin
        obs_valid = 1'b0;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    max_obs = 0;
    rst_n = 1'b0; pwdn = 1'b1; den = 1'b1; pclk = 1'b0;
    edge_sel = 1'b0; data = '0; cur_data = '0;
    repeat (3) @(negedge clk);
    chk(oe === 1'b0, "R1", "ser_oe_o in reset", 64'(oe), 64'd0);
    chk(ser === 1'b0, "R1", "ser_o in reset", 64'(ser), 64'd0);
    chk_bclk(1'b0, "R1");

    // release: R2 timing, falling-edge capture
    model_clear();
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    run_frames(2, 1'b1, 1'b0, '0, 1'b1, "R2");
    run_frames(8, 1'b1, 1'b0, '0, 1'b1, "R6");

    // no parallel clock: word repeats
    run_frames(3, 1'b0, 1'b0, '0, 1'b1, "R7");

    // unbalanced runs drive the disparity rule to its edges
    run_frames(4, 1'b1, 1'b1, 24'hFFFFFF, 1'b1, "R4");
    run_frames(4, 1'b1, 1'b1, 24'h000000, 1'b1, "R4");
    run_frames(3, 1'b1, 1'b1, 24'hFFF000, 1'b1, "R4");
    run_frames(3, 1'b1, 1'b1, 24'h000FFF, 1'b1, "R4");
    run_frames(3, 1'b1, 1'b1, 24'h03F03F, 1'b1, "R4");
    run_frames(3, 1'b1, 1'b1, 24'h7FFFFE, 1'b1, "R4");
    run_frames(3, 1'b1, 1'b1, 24'h001001, 1'b1, "R4");
    chk(max_obs <= 13, "R5", "observed disparity peak", 64'(max_obs), 64'd13);

    // data enable off, framing continues
    run_frames(1, 1'b1, 1'b0, '0, 1'b0, "R8");
    run_frames(3, 1'b1, 1'b0, '0, 1'b0, "R8");
    run_frames(4, 1'b1, 1'b0, '0, 1'b1, "R8");
    run_frames(1, 1'b1, 1'b0, '0, 1'b0, "R8");
    chk_bclk(1'b1, "R8");

    // standby
    pwdn = 1'b0;
    repeat (4) @(negedge clk);
    chk(oe === 1'b0, "R9", "ser_oe_o in standby", 64'(oe), 64'd0);
    chk(ser === 1'b0, "R9", "ser_o in standby", 64'(ser), 64'd0);
    chk_bclk(1'b0, "R9");
    edge_sel = 1'b1;
    den = 1'b1;
    repeat (3) @(negedge clk);

    // wake: training again, cleared word, then rising-edge capture
    model_clear();
    pwdn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    run_frames(4, 1'b0, 1'b0, '0, 1'b1, "R9");
    run_frames(8, 1'b1, 1'b0, '0, 1'b1, "R6");
    run_frames(3, 1'b1, 1'b1, 24'hFFFFFF, 1'b1, "R4");
    chk(max_obs <= 13, "R5", "observed disparity peak", 64'(max_obs), 64'd13);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule